// File: doc/BRIEF.md
# Sequential Signed/Unsigned Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor using a restoring shift-and-subtract loop that retires one quotient bit per clock. A mode input chooses two's-complement or unsigned interpretation of both operands. A second input chooses whether the reported result is the quotient or the remainder. In signed mode the operands are reduced to magnitudes first, the loop runs on those magnitudes, and a final cycle restores the sign.

A caller pulses `start` while the block is idle and keeps the operands and mode inputs steady for that cycle. It then waits for the single-cycle `done` pulse, when `result` and `div_zero` are valid. A zero divisor is caught at once: no iterations run, the result is zero, and the zero flag is raised on the very next cycle.

Top module: `sdiv_seq`

## Requirements
- R1: With `is_signed`=0 and `want_rem`=0, `result` equals the unsigned quotient floor(dividend/divisor).
- R2: With `is_signed`=0 and `want_rem`=1, `result` equals the unsigned remainder dividend mod divisor.
- R3: With `is_signed`=1 and `want_rem`=0, `result` is the two's-complement quotient truncated toward zero. It is negative exactly when the operand signs differ, and the most negative dividend divided by -1 wraps to 0x80000000.
- R4: With `is_signed`=1 and `want_rem`=1, `result` is the remainder. It carries the dividend's sign whatever the divisor's sign, and its magnitude is below the divisor's magnitude.
- R5: A start with divisor zero raises `done` and `div_zero` on the cycle after the start edge, and `result` is 0 at that point. `busy` stays low throughout.
- R6: A start with a non-zero divisor raises `busy` from the cycle after the start edge. `done` pulses for exactly one cycle 33 clock edges after the start edge, which is the edge on which `busy` falls.
- R7: A `start` asserted while `busy` is high has no effect. The running operation completes at its scheduled cycle with its own operands.
- R8: A start with a non-zero divisor clears `div_zero` on the cycle after the start edge.
- R9: Divisors with the top bit set are divided correctly in unsigned mode. This includes cases where the shifted partial remainder overflows 32 bits.
- R10: After synchronous active-low reset, `busy`, `done`, `div_zero` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| want_rem | input | 1 | 1: report remainder, 0: report quotient |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 32 | Quotient or remainder, held until the next completion |
| div_zero | output | 1 | Last accepted operation had a zero divisor |

## Verification
For a non-zero divisor the result is due 33 edges after the start edge. For a zero divisor it is due on the first edge after the start edge. `busy` rises one edge after the start edge. The bench runs a behavioural model with a countdown that is loaded on the same edge on which the design samples `start`. Each half period after the edge, it compares `busy`, `done`, `div_zero` and `result` against that model. Every deviation in timing or value is therefore caught on the exact cycle where it occurs, including a start pulse that arrives during a running division.

// File: rtl/sdiv_pkg.sv
// Shared definitions for the sequential divider.
// Assumes: nothing beyond standard SystemVerilog.
package sdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_prep.sv
// Operand conditioning: in signed mode it turns negative operands into
// magnitudes and reports their signs. In unsigned mode it passes them through.
// Assumes: operands are two's complement when is_signed is high.
module sdiv_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] dvd_in,
    input  logic [W-1:0] dvs_in,
    input  logic         is_signed,
    output logic [W-1:0] dvd_mag,
    output logic [W-1:0] dvs_mag,
    output logic         dvd_neg,
    output logic         dvs_neg
);
    // Sign detection and conditional negation.
    always_comb begin
        dvd_neg = is_signed & dvd_in[W-1];
        dvs_neg = is_signed & dvs_in[W-1];
        dvd_mag = dvd_neg ? (~dvd_in + W'(1)) : dvd_in;
        dvs_mag = dvs_neg ? (~dvs_in + W'(1)) : dvs_in;
    end
endmodule

// File: rtl/sdiv_step.sv
// One restoring iteration: it shifts the quotient MSB into the partial
// remainder and subtracts the divisor when the result fits.
// Assumes: rem_in < dvs on entry, so the result stays below dvs.
module sdiv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    logic [W:0] shifted;

    // Shift, compare (a carry-out forces the subtract) and build the quotient bit.
    always_comb begin
        shifted = {rem_in, quo_in[W-1]};
        if (shifted[W] || (shifted[W-1:0] >= dvs)) begin
            rem_out = shifted[W-1:0] - dvs;
            quo_out = {quo_in[W-2:0], 1'b1};
        end else begin
            rem_out = shifted[W-1:0];
            quo_out = {quo_in[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sdiv_post.sv
// Result selection and sign restoration after the loop.
// Assumes: q_neg/r_neg are already cleared in unsigned mode.
module sdiv_post #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    input  logic         sel_rem,
    input  logic         q_neg,
    input  logic         r_neg,
    output logic [W-1:0] res
);
    logic [W-1:0] pick;
    logic         flip;

    // Pick quotient or remainder and negate it when its sign flag is set.
    always_comb begin
        pick = sel_rem ? rem : quo;
        flip = sel_rem ? r_neg : q_neg;
        res  = flip ? (~pick + W'(1)) : pick;
    end
endmodule

// File: rtl/sdiv_seq.sv
// Sequential divider top: accepts a start when idle, runs W restoring
// iterations, and then spends one cycle on sign correction. A zero divisor
// completes on the next cycle with a zero result and the zero flag set.
// Assumes: operands and mode inputs are valid in the cycle start is high.
module sdiv_seq
    import sdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic         want_rem,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic         div_zero
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    sdiv_state_e   state;
    logic [CW-1:0] cnt;
    logic [W-1:0]  rem_q, quo_q, dvs_q;
    logic          q_neg, r_neg, sel_rem;

    logic [W-1:0]  dvd_mag, dvs_mag, rem_nx, quo_nx, res_fix;
    logic          dvd_neg, dvs_neg;

    sdiv_prep #(.W(W)) u_prep (
        .dvd_in   (dividend),
        .dvs_in   (divisor),
        .is_signed(is_signed),
        .dvd_mag  (dvd_mag),
        .dvs_mag  (dvs_mag),
        .dvd_neg  (dvd_neg),
        .dvs_neg  (dvs_neg)
    );

    sdiv_step #(.W(W)) u_step (
        .rem_in (rem_q),
        .quo_in (quo_q),
        .dvs    (dvs_q),
        .rem_out(rem_nx),
        .quo_out(quo_nx)
    );

    sdiv_post #(.W(W)) u_post (
        .quo    (quo_q),
        .rem    (rem_q),
        .sel_rem(sel_rem),
        .q_neg  (q_neg),
        .r_neg  (r_neg),
        .res    (res_fix)
    );

    // Busy whenever an accepted division is still under way.
    assign busy = (state != ST_IDLE);

    // Control sequence, datapath registers and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            rem_q    <= '0;
            quo_q    <= '0;
            dvs_q    <= '0;
            q_neg    <= 1'b0;
            r_neg    <= 1'b0;
            sel_rem  <= 1'b0;
            done     <= 1'b0;
            result   <= '0;
            div_zero <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (divisor == '0) begin
                            done     <= 1'b1;
                            result   <= '0;
                            div_zero <= 1'b1;
                        end else begin
                            div_zero <= 1'b0;
                            quo_q    <= dvd_mag;
                            rem_q    <= '0;
                            dvs_q    <= dvs_mag;
                            q_neg    <= dvd_neg ^ dvs_neg;
                            r_neg    <= dvd_neg;
                            sel_rem  <= want_rem;
                            cnt      <= '0;
                            state    <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    rem_q <= rem_nx;
                    quo_q <= quo_nx;
                    cnt   <= cnt + CW'(1);
                    if (cnt == LAST) begin
                        state <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    result <= res_fix;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R6
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);  // R6
    AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=> (done && div_zero && result == '0 && !busy));  // R5
    AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor != '0) |=> (!div_zero && busy));  // R8
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (rem_q < dvs_q));  // R4
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state == ST_RUN && cnt != LAST) |=> (state == ST_RUN));  // R7
endmodule

// File: tb/tb_sdiv_seq.sv
module tb_sdiv_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic        want_rem = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, div_zero;
    logic [31:0] result;

    sdiv_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .want_rem(want_rem), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .result(result), .div_zero(div_zero)
    );

    always #10 clk = ~clk;  // 50 MHz

    int errors = 0;
    int checks = 0;
    string cur_req = "R10";

    // Behavioural model state.
    int          m_cnt = 0;
    logic        m_done = 1'b0;
    logic        m_dz = 1'b0;
    logic [31:0] m_res = '0;
    logic [31:0] m_pend = '0;

    function automatic logic [31:0] ref_div(input logic sg, input logic rm,
                                            input logic [31:0] a, input logic [31:0] b);
        longint x, y, q, r;
        if (sg) begin
            x = longint'($signed(a));
            y = longint'($signed(b));
        end else begin
            x = longint'({32'd0, a});
            y = longint'({32'd0, b});
        end
        q = x / y;
        r = x % y;
        return rm ? r[31:0] : q[31:0];
    endfunction

    // Model: evolves on the same edge the design samples.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 1'b0; m_dz = 1'b0; m_res = '0;
        end else begin
            m_done = 1'b0;
            if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_done = 1'b1;
                    m_res = m_pend;
                end
            end else if (start) begin
                if (divisor == 32'd0) begin
                    m_done = 1'b1; m_dz = 1'b1; m_res = '0;
                end else begin
                    m_dz = 1'b0;
                    m_cnt = 33;
                    m_pend = ref_div(is_signed, want_rem, dividend, divisor);
                end
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("busy", {31'd0, busy}, {31'd0, (m_cnt > 0)});
            chk("done", {31'd0, done}, {31'd0, m_done});
            chk("div_zero", {31'd0, div_zero}, {31'd0, m_dz});
            chk("result", result, m_res);
        end
    end

    task automatic launch(input string req, input logic sg, input logic rm,
                          input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cur_req = req;
        is_signed = sg; want_rem = rm; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_op();
        while (m_cnt > 0 || busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input string req, input logic sg, input logic rm,
                       input logic [31:0] a, input logic [31:0] b);
        launch(req, sg, rm, a, b);
        finish_op();
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<=50000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state, checked while still in reset
        cur_req = "R10";
        chk("busy", {31'd0, busy}, 32'd0);
        chk("done", {31'd0, done}, 32'd0);
        chk("div_zero", {31'd0, div_zero}, 32'd0);
        chk("result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run("R1", 0, 0, 32'd100, 32'd7);
        run("R1", 0, 0, 32'hFFFF_FFFF, 32'd3);
        run("R1", 0, 0, 32'd5, 32'd9);
        run("R2", 0, 1, 32'd100, 32'd7);
        run("R2", 0, 1, 32'hDEAD_BEEF, 32'h0001_0000);
        run("R3", 1, 0, -32'sd100, 32'd7);
        run("R3", 1, 0, 32'd100, -32'sd7);
        run("R3", 1, 0, -32'sd100, -32'sd7);
        run("R3", 1, 0, 32'h8000_0000, 32'hFFFF_FFFF);
        run("R4", 1, 1, -32'sd100, 32'd7);
        run("R4", 1, 1, 32'd100, -32'sd7);
        run("R4", 1, 1, -32'sd100, -32'sd7);
        run("R4", 1, 1, 32'h8000_0000, 32'd3);
        run("R5", 0, 0, 32'd1234, 32'd0);
        run("R8", 1, 1, 32'd50, 32'd8);
        run("R5", 1, 1, -32'sd1, 32'd0);
        run("R9", 0, 0, 32'hFFFF_FFFF, 32'h8000_0001);
        run("R9", 0, 1, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
        run("R9", 0, 1, 32'hFFFF_FFFF, 32'hC000_0000);
        // R7: a second start during a running division is ignored
        launch("R7", 0, 0, 32'd1000, 32'd10);
        repeat (5) @(negedge clk);
        is_signed = 1'b1; want_rem = 1'b1; dividend = 32'd77; divisor = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_op();
        // R6: timing of done checked on every cycle by the model above
        run("R6", 0, 0, 32'd1, 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule